// File: doc/BRIEF.md
# Active-Low Network Interrupt Aggregator

This block gathers per-port network interrupt requests from three module bays into two 16-bit status words and drives one combined network interrupt line toward the processor. A bit in a status word reads 0 while its port has an interrupt pending and reads 1 when it is idle. Peripheral logic raises a request by pulsing a "set" strobe and drops it by pulsing a "clear" strobe. Each strobe carries a slot number and a port number. A fixed per-slot table turns the slot into a status word and a bit offset. The port number is added to that offset.

The CPU reads both status words through a single-cycle read strobe at two byte offsets. Writes to those offsets have no effect. The combined interrupt line is held by a two-state machine. It has the states IRQ_QUIET and IRQ_RAISED. The transition RAISE_ON_PENDING moves QUIET to RAISED when any status bit is 0. The transition DROP_ON_IDLE moves RAISED to QUIET when both words read all ones. Each state keeps itself otherwise, through HOLD_QUIET and HOLD_RAISED. The machine samples the registered status, so the line follows a status change one clock later.

Top module: `net_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, both status words hold 0xFFFF and `net_irq` is 0.
- R2: A set strobe with a valid slot and port drives the mapped status bit to 0 at the next clock edge.
- R3: A clear strobe with a valid slot and port drives the mapped status bit to 1 at the next clock edge.
- R4: Slot 0 maps to status word 0 at bit offset 0. Slot 1 maps to status word 1 at bit offset 0. Slot 2 maps to status word 1 at bit offset 8. The bit index is the offset plus the port number, and each slot owns 8 bits.
- R5: `net_irq` is 1 in the cycle after any status bit of either word is 0. It is 0 in the cycle after both words read 0xFFFF.
- R6: While `rd_en` is 1, `rdata` shows status word 0 at address 0x26, status word 1 at address 0x28, and 0 at any other address. The value is the registered status at the start of the cycle, with no added delay. While `rd_en` is 0, `rdata` is 0.
- R7: A write (`wr_en` with any address and data) changes no status bit.
- R8: When a set and a clear target the same bit in the same cycle, the bit becomes 0.
- R9: A strobe with slot 3, or with a port number of 8 or more, changes no status bit.
- R10: A set and a clear that target different bits in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| set_vld | input | 1 | Strobe that raises a request for (set_slot, set_port) |
| set_slot | input | 2 | Slot number for the set strobe |
| set_port | input | 4 | Port number for the set strobe |
| clr_vld | input | 1 | Strobe that drops a request for (clr_slot, clr_port) |
| clr_slot | input | 2 | Slot number for the clear strobe |
| clr_port | input | 4 | Port number for the clear strobe |
| rd_en | input | 1 | Single-cycle CPU read strobe |
| wr_en | input | 1 | Single-cycle CPU write strobe (ignored) |
| addr | input | 8 | CPU byte offset |
| wdata | input | 16 | CPU write data (ignored) |
| rdata | output | 16 | CPU read data |
| net_irq | output | 1 | Combined network interrupt, active high |

## Verification
Two functions can fall in the same cycle: a set strobe and a clear strobe. They may aim at the same bit or at different bits. The bench drives both strobes in one cycle, first at one shared bit and then at two separate bits. A behavioural reference model, which applies the clear before the set, predicts the outcome. The status words are then read back on the following cycle. A shared bit must end at 0, and separate bits must each take their own new value. The interrupt line is compared with the model on every cycle, so the line's one-cycle lag is also checked across these collisions.

// File: rtl/nia_pkg.sv
package nia_pkg;
    localparam int REG_W     = 16;
    localparam int NUM_REGS  = 2;
    localparam int FIELD_W   = 8;
    localparam int NUM_SLOTS = 3;
    localparam int SLOT_W    = 2;
    localparam int PORT_W    = 4;
    localparam int ADDR_W    = 8;

    localparam logic [ADDR_W-1:0] OFS_STAT0 = 8'h26;
    localparam logic [ADDR_W-1:0] OFS_STAT1 = 8'h28;

    typedef logic [NUM_REGS-1:0][REG_W-1:0] bank_t;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;

    // status word used by a slot
    function automatic int slot_reg(input int s);
        return (s == 0) ? 0 : 1;
    endfunction

    // first bit of a slot's field inside its word
    function automatic int slot_off(input int s);
        return (s == 2) ? FIELD_W : 0;
    endfunction
endpackage

// File: rtl/nia_slot_decode.sv
module nia_slot_decode
    import nia_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic [SLOT_W-1:0] slot,
    input  logic [PORT_W-1:0] port,
    output bank_t             mask
);
    logic port_ok;
    assign port_ok = (port < PORT_W'(FIELD_W));

    always_comb begin
        mask = '0;
        if (vld && port_ok) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (slot == SLOT_W'(s)) begin
                    mask[slot_reg(s)][slot_off(s) + int'(port)] = 1'b1;
                end
            end
        end
    end

    // R4
    dec_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mask));

    // R9
    dec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && (slot == SLOT_W'(3) || port >= PORT_W'(FIELD_W))) |-> (mask == '0));
endmodule

// File: rtl/nia_status_bank.sv
module nia_status_bank
    import nia_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  bank_t set_mask,
    input  bank_t clr_mask,
    output bank_t stat_q
);
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stat_q[r] <= '1;
            end else begin
                stat_q[r] <= (stat_q[r] | clr_mask[r]) & ~set_mask[r];
            end
        end
    end

    // R1
    bank_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (stat_q == '1));

    // R2
    bank_set_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask != '0) |=> ((stat_q & $past(set_mask)) == '0));

    // R3
    bank_clr_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~set_mask) != '0) |=>
            ((stat_q & $past(clr_mask & ~set_mask)) == $past(clr_mask & ~set_mask)));

    // R8
    bank_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_mask & clr_mask) != '0) |=> ((stat_q & $past(set_mask & clr_mask)) == '0));

    // R9
    bank_idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_mask == '0 && clr_mask == '0) |=> $stable(stat_q));
endmodule

// File: rtl/nia_irq_fsm.sv
module nia_irq_fsm
    import nia_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  bank_t stat_q,
    output logic  net_irq
);
    irq_state_e state_q, state_d;
    logic       pending;

    assign pending = (stat_q != '1);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED; // RAISE_ON_PENDING
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;  // DROP_ON_IDLE
            default:    state_d = IRQ_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            IRQ_RAISED: net_irq = 1'b1;
            default:    net_irq = 1'b0;
        endcase
    end

    // R5
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q != '1) |=> net_irq);

    // R5
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == '1) |=> !net_irq);

    // R1
    irq_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !net_irq);
endmodule

// File: rtl/net_irq_agg.sv
module net_irq_agg
    import nia_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_vld,
    input  logic [SLOT_W-1:0] set_slot,
    input  logic [PORT_W-1:0] set_port,
    input  logic              clr_vld,
    input  logic [SLOT_W-1:0] clr_slot,
    input  logic [PORT_W-1:0] clr_port,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              net_irq
);
    bank_t set_mask, clr_mask, stat_q;
    logic  unused_wr;

    assign unused_wr = ^{wr_en, wdata};

    nia_slot_decode u_set_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .vld  (set_vld),
        .slot (set_slot),
        .port (set_port),
        .mask (set_mask)
    );

    nia_slot_decode u_clr_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .vld  (clr_vld),
        .slot (clr_slot),
        .port (clr_port),
        .mask (clr_mask)
    );

    nia_status_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_mask(set_mask),
        .clr_mask(clr_mask),
        .stat_q  (stat_q)
    );

    nia_irq_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_q (stat_q),
        .net_irq(net_irq)
    );

    // CPU read port
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                OFS_STAT0: rdata = stat_q[0];
                OFS_STAT1: rdata = stat_q[1];
                default:   rdata = '0;
            endcase
        end
    end

    // R7
    wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !set_vld && !clr_vld) |=> $stable(stat_q));

    // R6
    rd_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

// File: tb/sim_net_irq_agg.sv
module sim_net_irq_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_vld = 1'b0, clr_vld = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  set_slot = '0, clr_slot = '0;
    logic [3:0]  set_port = '0, clr_port = '0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        net_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [15:0] m_word [2];
    bit          m_irq;

    always #10 clk = ~clk;

    net_irq_agg u0 (
        .clk(clk), .rst_n(rst_n),
        .set_vld(set_vld), .set_slot(set_slot), .set_port(set_port),
        .clr_vld(clr_vld), .clr_slot(clr_slot), .clr_port(clr_port),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .net_irq(net_irq)
    );

    function automatic bit map_pos(input int s, input int p, output int w, output int b);
        w = 0;
        b = 0;
        if (s < 0 || s > 2 || p < 0 || p > 7) return 1'b0;
        w = (s == 0) ? 0 : 1;
        b = ((s == 2) ? 8 : 0) + p;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        int w, b;
        if (!rst_n) begin
            m_word[0] = 16'hFFFF;
            m_word[1] = 16'hFFFF;
            m_irq     = 1'b0;
        end else begin
            m_irq = (m_word[0] != 16'hFFFF) || (m_word[1] != 16'hFFFF);
            if (clr_vld && map_pos(int'(clr_slot), int'(clr_port), w, b)) m_word[w][b] = 1'b1;
            if (set_vld && map_pos(int'(set_slot), int'(set_port), w, b)) m_word[w][b] = 1'b0;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input string tag,
                       input bit sv, input int ss, input int sp,
                       input bit cv, input int cs, input int cp,
                       input bit rd, input bit wr, input int a, input int wd);
        int exp_rd;
        @(negedge clk);
        set_vld = sv; set_slot = 2'(ss); set_port = 4'(sp);
        clr_vld = cv; clr_slot = 2'(cs); clr_port = 4'(cp);
        rd_en = rd; wr_en = wr; addr = 8'(a); wdata = 16'(wd);
        #5;
        exp_rd = 0;
        if (rd && a == 'h26) exp_rd = int'(m_word[0]);
        if (rd && a == 'h28) exp_rd = int'(m_word[1]);
        check(tag, "rdata", int'(rdata), exp_rd);
        check(tag, "net_irq", int'(net_irq), int'(m_irq));
    endtask

    task automatic do_set(input string tag, input int s, input int p);
        cyc(tag, 1, s, p, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic do_clr(input string tag, input int s, input int p);
        cyc(tag, 0, 0, 0, 1, s, p, 0, 0, 0, 0);
    endtask
    task automatic rd(input string tag, input int a);
        cyc(tag, 0, 0, 0, 0, 0, 0, 1, 0, a, 0);
    endtask
    task automatic idle(input string tag);
        cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd("R1", 'h26); rd("R1", 'h28);

        // R2 set on slot 0, then R5 lag of the line
        do_set("R2", 0, 3);
        rd("R2", 'h26);
        rd("R5", 'h26);

        // R4 slot mapping into word 1
        do_set("R4", 1, 0);
        do_set("R4", 2, 7);
        rd("R4", 'h28);

        // R3 drop everything, R5 line falls a cycle later
        do_clr("R3", 0, 3);
        do_clr("R3", 1, 0);
        do_clr("R3", 2, 7);
        rd("R3", 'h28);
        rd("R5", 'h26);

        // R8 same bit, set and clear together
        cyc("R8", 1, 2, 4, 1, 2, 4, 0, 0, 0, 0);
        rd("R8", 'h28);

        // R10 different bits together
        cyc("R10", 1, 0, 5, 1, 2, 4, 0, 0, 0, 0);
        rd("R10", 'h26); rd("R10", 'h28);

        // R9 out-of-range strobes
        do_set("R9", 3, 1);
        do_set("R9", 1, 9);
        do_set("R9", 2, 15);
        do_clr("R9", 0, 13);
        rd("R9", 'h26); rd("R9", 'h28);

        // R7 writes of zero to both offsets
        cyc("R7", 0, 0, 0, 0, 0, 0, 0, 1, 'h26, 0);
        cyc("R7", 0, 0, 0, 0, 0, 0, 0, 1, 'h28, 0);
        rd("R7", 'h26); rd("R7", 'h28);

        // R6 other addresses and read idle
        rd("R6", 'h30);
        rd("R6", 'h27);
        cyc("R6", 0, 0, 0, 0, 0, 0, 0, 0, 'h26, 0);

        // R4 sweep of every slot and port
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 8; p++) begin
                do_set("R4", s, p);
                rd("R4", (s == 0) ? 'h26 : 'h28);
            end
        end
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 8; p++) begin
                cyc("R3", 0, 0, 0, 1, s, p, 1, 0, (s == 0) ? 'h26 : 'h28, 0);
            end
        end
        do_clr("R3", 0, 5);
        idle("R5"); idle("R5");
        rd("R5", 'h26); rd("R5", 'h28);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule